// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a bank of eleven performance counters behind a small register window. Slot 0 holds a 64-bit counter that advances on every clock. Slots 1 to 10 each hold a 32-bit counter. Each of these picks one line out of its own 128-line group of event pulses, using a 7-bit code in its control word. Software reaches the bank through a write strobe, an address and write data. Reads are combinational from the address.

Any counter can be frozen on its own. One global freeze bit stops all of them at once. Software can arm an overflow condition: when an armed counter's top bit goes from 0 to 1 as it counts, the hardware sets the global freeze bit, which stops every counter, and raises a level interrupt. The interrupt stays up until software has cleared the global freeze bit and rewritten the overflowing counter so that its top bit is 0. A typical sequence is: freeze, clear the counters, program the event codes, then release the global freeze.

Top module: `evtmon_bank`

## Requirements
- R1: After reset the global word reads 0x8000_0000 (freeze-all set, both enables clear), every counter, control A and control B word reads 0, and `irq` is low.
- R2: The global word sits at 0x40 with freeze-all in bit 31, interrupt enable in bit 30 and freeze-on-condition enable in bit 29. Slot n has control A at 0x50+0x10*n, control B at +4, the counter value at +8 and, for slot 0 only, the counter's upper half at +0xC. Control A holds the local freeze in bit 31, the condition enable in bit 26 and the event code in bits 22:16. Control B is 32 bits of storage that read back as written. All other bits of the global word and control A read 0.
- R3: The slot 0 counter adds one on every clock in which it is not frozen. It is 64 bits wide, so a carry out of the lower half reaches the upper half.
- R4: Slot n (1 to 10) adds one in a cycle where `evt_bus[n*128 + code]` is high and the slot is not frozen, where code is its 7-bit event code.
- R5: A counter whose local freeze bit is set, or any counter while the global freeze-all bit is set, holds its value whatever its events do.
- R6: A write to a value register loads the write data in the next cycle, so a written zero clears the counter. If the counter has an event in the same cycle, the write takes precedence.
- R7: When a counter's top bit (bit 31, or bit 63 for slot 0) goes from 0 to 1 as it counts, and its condition enable, the global interrupt enable and the global freeze-on-condition bit are all 1, the next cycle shows freeze-all set in the global word, `irq` high and every counter stopped.
- R8: If any one of those three enables is 0, the counter counts through its top bit without raising `irq` and without setting freeze-all.
- R9: Once raised, `irq` stays high while freeze-all is set or the overflowing counter's top bit is 1. It drops one cycle after both are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |
| evt_bus | input | 1408 | Event pulses: 128 lines per slot, slot n at bits n*128 to n*128+127 |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest state to reach is an armed counter crossing its top bit. Counting up to it would take about 2^31 events, or 2^63 clocks for the cycle counter. The stimulus therefore preloads the value registers (both halves for slot 0) a step or two below the boundary, and then lets events or cycles carry the counter across. Each of the three enables is left clear in turn to confirm that the crossing stays silent. The release sequence follows, where freeze-all and the top bit are cleared separately, so that the interrupt can be seen to stay up until the second of the two is cleared. Constrained-random event traffic, with random event codes and random local freezes, exercises the counting paths in between.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;
  localparam int EVT_CODE_W  = 7;
  localparam int GCTL_OFS    = 'h40;
  localparam int SLOT_BASE   = 'h50;
  localparam int SLOT_STRIDE = 'h10;
  localparam int OFS_CTLA    = 'h0;
  localparam int OFS_CTLB    = 'h4;
  localparam int OFS_VAL     = 'h8;
  localparam int OFS_VALHI   = 'hC;
  // global word bit positions
  localparam int GB_FRZALL   = 31;
  localparam int GB_IRQEN    = 30;
  localparam int GB_FRZCOND  = 29;
  // local control A bit positions
  localparam int LB_FRZ      = 31;
  localparam int LB_CONDEN   = 26;
  localparam int LB_SEL_LO   = 16;

  typedef struct packed {
    logic                  frz;
    logic                  cond_en;
    logic [EVT_CODE_W-1:0] sel;
  } lctl_t;

  function automatic logic [31:0] lctl_word(lctl_t c);
    logic [31:0] w;
    w = '0;
    w[LB_FRZ]    = c.frz;
    w[LB_CONDEN] = c.cond_en;
    w[LB_SEL_LO +: EVT_CODE_W] = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/evtmon_slot.sv
module evtmon_slot
  import evtmon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DATA_W   = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frz_all,
  input  logic                        wr_ctla,
  input  logic                        wr_ctlb,
  input  logic                        wr_lo,
  input  logic                        wr_hi,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [(1<<EVT_CODE_W)-1:0]  evt,
  output lctl_t                       ctla,
  output logic [DATA_W-1:0]           ctlb,
  output logic [CNT_W-1:0]            val,
  output logic                        ovf
);
  lctl_t              ctla_q, ctla_d;
  logic [DATA_W-1:0]  ctlb_q;
  logic [CNT_W-1:0]   val_q, val_d, inc, wr_val;
  logic               hit, cnt_en, any_wr, val_en;

  always_comb begin
    hit    = IS_CYCLE ? 1'b1 : evt[ctla_q.sel];
    cnt_en = hit && !ctla_q.frz && !frz_all;
    any_wr = wr_lo || wr_hi;
    inc    = val_q + CNT_W'(1);
    val_en = any_wr || cnt_en;
    val_d  = any_wr ? wr_val : inc;
    // carry into the top bit caused by counting, never by a write
    ovf    = cnt_en && !any_wr && !val_q[CNT_W-1] && inc[CNT_W-1];
    ctla_d = '{frz:     wdata[LB_FRZ],
               cond_en: wdata[LB_CONDEN],
               sel:     wdata[LB_SEL_LO +: EVT_CODE_W]};
  end

  generate
    if (CNT_W > DATA_W) begin : g_split
      always_comb
        wr_val = {wr_hi ? wdata[CNT_W-DATA_W-1:0] : val_q[CNT_W-1:DATA_W],
                  wr_lo ? wdata : val_q[DATA_W-1:0]};
    end else begin : g_single
      always_comb
        wr_val = wr_lo ? wdata[CNT_W-1:0] : val_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q <= '0;
      ctlb_q <= '0;
      val_q  <= '0;
    end else begin
      if (wr_ctla) ctla_q <= ctla_d;
      if (wr_ctlb) ctlb_q <= wdata;
      if (val_en)  val_q  <= val_d;
    end
  end

  assign ctla = ctla_q;
  assign ctlb = ctlb_q;
  assign val  = val_q;
endmodule

// File: rtl/evtmon_gctl.sv
module evtmon_gctl #(
  parameter int NUM_CTR = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_gctl,
  input  logic               w_frz,
  input  logic               w_ien,
  input  logic               w_fcond,
  input  logic [NUM_CTR-1:0] trig,
  input  logic [NUM_CTR-1:0] msb,
  output logic               frz_all,
  output logic               irq_en,
  output logic               frz_cond,
  output logic               irq
);
  logic               frz_q, ien_q, fc_q;
  logic               frz_d, ien_d, fc_d, fire, frz_en;
  logic [NUM_CTR-1:0] src_q, src_d;

  always_comb begin
    fire   = (|trig) && ien_q && fc_q;
    frz_en = fire || wr_gctl;
    frz_d  = fire ? 1'b1 : w_frz;   // hardware set beats a software write
    ien_d  = w_ien;
    fc_d   = w_fcond;
    for (int i = 0; i < NUM_CTR; i++) begin
      src_d[i] = (fire && trig[i]) || (src_q[i] && (frz_q || msb[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b1;
      ien_q <= 1'b0;
      fc_q  <= 1'b0;
      src_q <= '0;
    end else begin
      if (frz_en)  frz_q <= frz_d;
      if (wr_gctl) ien_q <= ien_d;
      if (wr_gctl) fc_q  <= fc_d;
      src_q <= src_d;
    end
  end

  assign frz_all  = frz_q;
  assign irq_en   = ien_q;
  assign frz_cond = fc_q;
  assign irq      = |src_q;
endmodule

// File: rtl/evtmon_bank.sv
module evtmon_bank
  import evtmon_pkg::*;
#(
  parameter int NUM_CTR = 11,
  parameter int CTR_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [DATA_W-1:0]                     rdata,
  input  logic [NUM_CTR*(1<<EVT_CODE_W)-1:0]    evt_bus,
  output logic                                  irq
);
  localparam int CYC_W = 2 * DATA_W;
  localparam int NEVT  = 1 << EVT_CODE_W;

  function automatic logic [ADDR_W-1:0] slot_addr(int idx, int sub);
    return ADDR_W'(SLOT_BASE + idx * SLOT_STRIDE + sub);
  endfunction

  lctl_t                        ctla_s [NUM_CTR];
  logic [DATA_W-1:0]            ctlb_s [NUM_CTR];
  logic [CYC_W-1:0]             cyc_val;
  logic [(NUM_CTR-1)*CTR_W-1:0] ctr_flat;
  logic [NUM_CTR-1:0]           ovf_s, trig_s, msb_s;
  logic                         frz_all, irq_en, frz_cond, wr_g;

  assign wr_g = wr_en && (addr == ADDR_W'(GCTL_OFS));

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
      logic wa, wb, wl;
      assign wa = wr_en && (addr == slot_addr(i, OFS_CTLA));
      assign wb = wr_en && (addr == slot_addr(i, OFS_CTLB));
      assign wl = wr_en && (addr == slot_addr(i, OFS_VAL));
      assign trig_s[i] = ovf_s[i] && ctla_s[i].cond_en;
      if (i == 0) begin : g_cyc
        logic wh;
        assign wh = wr_en && (addr == slot_addr(i, OFS_VALHI));
        evtmon_slot #(.CNT_W(CYC_W), .DATA_W(DATA_W), .IS_CYCLE(1'b1)) u_slot (
          .clk(clk), .rst_n(rst_n), .frz_all(frz_all),
          .wr_ctla(wa), .wr_ctlb(wb), .wr_lo(wl), .wr_hi(wh),
          .wdata(wdata), .evt(evt_bus[i*NEVT +: NEVT]),
          .ctla(ctla_s[i]), .ctlb(ctlb_s[i]), .val(cyc_val), .ovf(ovf_s[i]));
        assign msb_s[i] = cyc_val[CYC_W-1];
      end else begin : g_evt
        evtmon_slot #(.CNT_W(CTR_W), .DATA_W(DATA_W), .IS_CYCLE(1'b0)) u_slot (
          .clk(clk), .rst_n(rst_n), .frz_all(frz_all),
          .wr_ctla(wa), .wr_ctlb(wb), .wr_lo(wl), .wr_hi(1'b0),
          .wdata(wdata), .evt(evt_bus[i*NEVT +: NEVT]),
          .ctla(ctla_s[i]), .ctlb(ctlb_s[i]),
          .val(ctr_flat[(i-1)*CTR_W +: CTR_W]), .ovf(ovf_s[i]));
        assign msb_s[i] = ctr_flat[i*CTR_W-1];
      end
    end
  endgenerate

  evtmon_gctl #(.NUM_CTR(NUM_CTR)) u_gctl (
    .clk(clk), .rst_n(rst_n), .wr_gctl(wr_g),
    .w_frz(wdata[GB_FRZALL]), .w_ien(wdata[GB_IRQEN]), .w_fcond(wdata[GB_FRZCOND]),
    .trig(trig_s), .msb(msb_s),
    .frz_all(frz_all), .irq_en(irq_en), .frz_cond(frz_cond), .irq(irq));

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(GCTL_OFS)) begin
      rdata[GB_FRZALL]  = frz_all;
      rdata[GB_IRQEN]   = irq_en;
      rdata[GB_FRZCOND] = frz_cond;
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == slot_addr(i, OFS_CTLA)) rdata = DATA_W'(lctl_word(ctla_s[i]));
      if (addr == slot_addr(i, OFS_CTLB)) rdata = ctlb_s[i];
    end
    if (addr == slot_addr(0, OFS_VAL))   rdata = cyc_val[DATA_W-1:0];
    if (addr == slot_addr(0, OFS_VALHI)) rdata = cyc_val[CYC_W-1:DATA_W];
    for (int i = 1; i < NUM_CTR; i++) begin
      if (addr == slot_addr(i, OFS_VAL)) rdata = DATA_W'(ctr_flat[(i-1)*CTR_W +: CTR_W]);
    end
  end
endmodule

// File: rtl/evtmon_chk.sv
module evtmon_chk #(
  parameter int NUM_CTR = 11,
  parameter int CTR_W   = 32,
  parameter int CYC_W   = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic                         irq,
  input logic                         frz_all,
  input logic                         irq_en,
  input logic                         frz_cond,
  input logic                         cyc_frz,
  input logic [CYC_W-1:0]             cyc_val,
  input logic [(NUM_CTR-1)*CTR_W-1:0] ctr_flat
);
  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_all && !wr_en) |=> ($stable(ctr_flat) && $stable(cyc_val)));

  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !frz_all && !cyc_frz) |=> (cyc_val == $past(cyc_val) + CYC_W'(1)));

  // R7
  irq_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> frz_all);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en && frz_cond));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && frz_all) |=> irq);
endmodule

bind evtmon_bank evtmon_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq),
  .frz_all(frz_all), .irq_en(irq_en), .frz_cond(frz_cond),
  .cyc_frz(ctla_s[0].frz), .cyc_val(cyc_val), .ctr_flat(ctr_flat)
);

// File: tb/evtmon_bank_tb_top.sv
`timescale 1ns/1ps
module evtmon_bank_tb_top;
  localparam int N    = 11;
  localparam int NEVT = 128;
  localparam logic [7:0] GCTL = 8'h40;

  logic              clk, rst_n, wr_en, irq;
  logic [7:0]        addr;
  logic [31:0]       wdata, rdata;
  logic [N*NEVT-1:0] evt;

  int n_chk, n_fail;
  logic [6:0]  sel  [N];
  logic        lfrz [N];
  int          expc [N];
  logic [31:0] d;

  evtmon_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_bus(evt), .irq(irq));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] a_ctla(int i); return 8'(8'h50 + 16*i); endfunction
  function automatic logic [7:0] a_ctlb(int i); return 8'(8'h54 + 16*i); endfunction
  function automatic logic [7:0] a_val(int i);  return 8'(8'h58 + 16*i); endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic fill_evt();
    for (int w = 0; w < N*NEVT/32; w++) evt[w*32 +: 32] = $urandom & $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-reqs act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(GCTL, d);        chk("R1 global word", d, 32'h8000_0000);
    chk("R1 irq", irq, 0);
    rd(a_val(0), d);    chk("R1 cycle lo", d, 0);
    rd(a_val(5), d);    chk("R1 counter5", d, 0);
    rd(a_ctla(3), d);   chk("R1 ctla3", d, 0);
    rd(a_ctlb(10), d);  chk("R1 ctlb10", d, 0);

    // R2 layout and reserved bits
    wr(a_ctla(2), 32'hFFFF_FFFF); rd(a_ctla(2), d); chk("R2 ctla fields", d, 32'h847F_0000);
    wr(a_ctla(2), 0);
    wr(a_ctlb(7), 32'hA5A5_1234); rd(a_ctlb(7), d); chk("R2 ctlb storage", d, 32'hA5A5_1234);
    wr(GCTL, 32'hFFFF_FFFF);      rd(GCTL, d);      chk("R2 global fields", d, 32'hE000_0000);
    wr(GCTL, 32'h8000_0000);

    // R3 R4 R5 random event traffic
    for (int r = 0; r < 3; r++) begin
      int k;
      wr(GCTL, 32'h8000_0000);
      for (int i = 0; i < N; i++) wr(a_val(i), 0);
      wr(8'h5C, 0);
      for (int i = 0; i < N; i++) begin
        sel[i]  = 7'($urandom);
        lfrz[i] = (i == 0) ? (r == 1) : ($urandom % 4 == 0);
        expc[i] = 0;
        wr(a_ctla(i), (lfrz[i] ? 32'h8000_0000 : 32'h0) | (32'(sel[i]) << 16));
      end
      k = 20 + int'($urandom % 30);
      wr(GCTL, 0);
      for (int j = 0; j < k; j++) begin
        fill_evt();
        for (int i = 1; i < N; i++)
          if (!lfrz[i] && evt[i*NEVT + int'(sel[i])]) expc[i]++;
        @(negedge clk);
      end
      evt = '0;
      wr(GCTL, 32'h8000_0000);
      expc[0] = lfrz[0] ? 0 : k + 1;
      rd(a_val(0), d); chk(lfrz[0] ? "R5 cycle local freeze" : "R3 cycle count", d, 64'(expc[0]));
      rd(8'h5C, d);    chk("R3 cycle hi", d, 0);
      for (int i = 1; i < N; i++) begin
        rd(a_val(i), d);
        chk(lfrz[i] ? "R5 local freeze" : "R4 event count", d, 64'(expc[i]));
      end
      // global freeze holds everything
      for (int j = 0; j < 4; j++) begin fill_evt(); @(negedge clk); end
      evt = '0;
      for (int i = 1; i < N; i++) begin
        rd(a_val(i), d); chk("R5 global freeze hold", d, 64'(expc[i]));
      end
    end

    // R6 write beats a same-cycle event, zero clears
    wr(GCTL, 32'h8000_0000);
    wr(a_ctla(4), 32'h0009_0000);
    wr(a_val(4), 32'h55);
    wr(GCTL, 0);
    evt[4*NEVT + 9] = 1'b1;
    wr(a_val(4), 32'h1234);
    evt = '0;
    wr(GCTL, 32'h8000_0000);
    rd(a_val(4), d); chk("R6 write wins", d, 32'h1234);
    wr(a_val(4), 0); rd(a_val(4), d); chk("R6 write zero", d, 0);

    // R7 R9 armed overflow on slot 3
    wr(a_ctla(3), 32'h0405_0000);
    wr(a_val(3), 32'h7FFF_FFFE);
    wr(a_ctla(6), 32'h0001_0000);
    wr(a_val(6), 0);
    wr(GCTL, 32'h6000_0000);
    evt[3*NEVT + 5] = 1'b1; @(negedge clk); evt = '0;
    chk("R7 no irq below boundary", irq, 0);
    evt[3*NEVT + 5] = 1'b1; evt[6*NEVT + 1] = 1'b1; @(negedge clk); evt = '0;
    chk("R7 irq raised", irq, 1);
    rd(GCTL, d);      chk("R7 freeze-all set by hw", d, 32'hE000_0000);
    rd(a_val(3), d);  chk("R7 counter at top bit", d, 32'h8000_0000);
    for (int j = 0; j < 3; j++) begin
      evt[3*NEVT + 5] = 1'b1; evt[6*NEVT + 1] = 1'b1; @(negedge clk);
    end
    evt = '0;
    rd(a_val(6), d);  chk("R7 other counter stopped", d, 1);
    wr(GCTL, 32'h6000_0000);
    @(negedge clk);
    chk("R9 irq held while msb set", irq, 1);
    wr(a_val(3), 0);
    @(negedge clk);
    chk("R9 irq released", irq, 0);

    // R8 each missing enable keeps the crossing silent
    for (int v = 0; v < 3; v++) begin
      logic [31:0] g;
      g = ((v != 0) ? 32'h4000_0000 : 32'h0) | ((v != 1) ? 32'h2000_0000 : 32'h0);
      wr(GCTL, 32'h8000_0000);
      wr(a_ctla(3), ((v != 2) ? 32'h0400_0000 : 32'h0) | 32'h0005_0000);
      wr(a_val(3), 32'h7FFF_FFFF);
      wr(GCTL, g);
      evt[3*NEVT + 5] = 1'b1; @(negedge clk); @(negedge clk); evt = '0;
      @(negedge clk);
      chk("R8 no irq", irq, 0);
      rd(GCTL, d);     chk("R8 no hw freeze", d, g);
      rd(a_val(3), d); chk("R8 counts through msb", d, 32'h8000_0001);
    end
    wr(GCTL, 32'h8000_0000);
    wr(a_val(3), 0);

    // R3 R7 64-bit carry on the cycle counter
    wr(a_ctla(0), 32'h0400_0000);
    wr(a_val(0), 32'hFFFF_FFFE);
    wr(8'h5C, 32'h7FFF_FFFF);
    wr(GCTL, 32'h6000_0000);
    @(negedge clk); @(negedge clk);
    chk("R7 cycle overflow irq", irq, 1);
    rd(8'h5C, d);    chk("R3 carry into hi", d, 32'h8000_0000);
    rd(a_val(0), d); chk("R3 lo wrapped", d, 0);
    wr(8'h5C, 0);
    chk("R9 irq held while frozen", irq, 1);
    wr(GCTL, 0);
    @(negedge clk);
    chk("R9 irq released cycle ctr", irq, 0);

    summary();
  end
endmodule